// File: doc/BRIEF.md
# Sobel Gradient Threshold Unit

This block turns a 3×3 neighbourhood of 8-bit grayscale pixels into a single binary edge pixel. Each cycle it can accept one window with a valid strobe. The two Sobel gradients (left-to-right and top-to-bottom) are formed in parallel from the same window. Each gradient is squared and the two squares are added. The sum is then compared with a fixed threshold of 4000, and no square root is taken.

A window whose squared-gradient sum is above the threshold becomes a full-white pixel. Any other window becomes black. Results leave a three-stage pipeline in the order the windows arrived, with a valid strobe that follows them. The unit sits after a line-buffer stage that builds the window and before whatever stores or streams the edge map. It has no flow control of its own.

Top module: `sobel_edge_thresh`

## Requirements
- R1: Pixel k of the window (k = 0..8) sits in bits [8k+7:8k], packed row by row with pixel 0 at the top-left. The horizontal gradient is gx = (p2 + 2·p5 + p8) − (p0 + 2·p3 + p6). Pixels are unsigned.
- R2: The vertical gradient is gy = (p6 + 2·p7 + p8) − (p0 + 2·p1 + p2). The centre pixel p4 contributes to neither gradient.
- R3: Gradients are signed. A negative gradient of any size, down to −1020, squares to the same value as its positive twin, and gx² + gy² never wraps for any window.
- R4: out_pix is 8'hFF when gx² + gy² is strictly greater than 4000. It is 8'h00 when the sum is 4000 or less, so a sum of exactly 4000 gives 8'h00.
- R5: A window accepted with in_valid high at a clock edge shows up on out_valid and out_pix three rising edges later. out_valid is in_valid delayed by exactly three cycles.
- R6: While out_valid is low, out_pix is 8'h00.
- R7: rst_n is synchronous and active-low. After any edge at which it is low, out_valid and out_pix are both zero, whatever in_valid was doing.
- R8: Windows presented on consecutive cycles with in_valid held high each produce their own result, one per cycle, in input order, with no bubble and no mixing between neighbours.
- R9: out_pix only ever takes the values 8'h00 and 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole pipeline |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks in_win as a window to be processed this cycle |
| in_win | input | 72 | Nine 8-bit pixels, row-major, pixel 0 in the low byte |
| out_valid | output | 1 | Marks out_pix as a result |
| out_pix | output | 8 | Binary edge pixel, 8'hFF for edge, 8'h00 otherwise |

## Verification
The hardest outcome to reach is a squared sum that lands exactly on the threshold. Random windows almost never produce a sum of 4000. The stimulus therefore places two hand-chosen pixels (gx = 60, gy = 20) to land on it exactly, and puts neighbours at 3844, 3872, 4050 and 4096 around it, which also pin down each kernel weight. Large negative gradients are forced with inverted full-contrast windows. Random low-contrast windows, built around a common base level with small noise, keep results near the threshold so that both outcomes occur often. A reset asserted while all three stages hold valid data shows that the flush reaches the outputs.

// File: rtl/sobel_edge_pkg.sv
// Package: shared sizes, axis selector and kernel coefficient function for
// the Sobel gradient threshold unit. Assumes a square 3x3 window, row-major.
package sobel_edge_pkg;

    localparam int PIX_W      = 8;
    localparam int WIN_SIDE   = 3;
    localparam int N_TAPS     = WIN_SIDE * WIN_SIDE;
    localparam int PIPE_DEPTH = 3;
    localparam int EDGE_THRESH = 4000;

    typedef enum logic {
        AXIS_X = 1'b0,   // left-to-right difference
        AXIS_Y = 1'b1    // top-to-bottom difference
    } axis_e;

    // Sobel weight of tap idx for the given axis: the sign follows the
    // column (X) or row (Y), and the weight doubles on the middle row/column.
    function automatic int tap_coef(axis_e ax, int idx);
        int row;
        int col;
        int mag;
        int dir;
        row = idx / WIN_SIDE;
        col = idx % WIN_SIDE;
        if (ax == AXIS_X) begin
            mag = (row == 1) ? 2 : 1;
            dir = col - 1;
        end else begin
            mag = (col == 1) ? 2 : 1;
            dir = row - 1;
        end
        return mag * dir;
    endfunction

endpackage

// File: rtl/sobel_axis_lane.sv
// Module: one gradient lane. Stage 1 registers the nine weighted taps of the
// window, and stage 2 registers their signed sum. Assumes unsigned pixels
// packed row-major with tap 0 in the low bits. The result is valid two edges
// after the window is presented.
module sobel_axis_lane #(
    parameter int                    PIX_W = sobel_edge_pkg::PIX_W,
    parameter sobel_edge_pkg::axis_e AXIS  = sobel_edge_pkg::AXIS_X
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [sobel_edge_pkg::N_TAPS*PIX_W-1:0] win,
    output logic signed [PIX_W+2:0]           grad
);

    localparam int N_TAPS = sobel_edge_pkg::N_TAPS;
    localparam int GRAD_W = PIX_W + 3;

    logic signed [GRAD_W-1:0] prod_d [N_TAPS];
    logic signed [GRAD_W-1:0] prod_q [N_TAPS];
    logic signed [GRAD_W-1:0] sum_d;
    logic signed [GRAD_W-1:0] grad_q;

    // Per-tap constant weighting; the coefficient is fixed at elaboration.
    for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
        localparam logic signed [GRAD_W-1:0] COEF =
            GRAD_W'(sobel_edge_pkg::tap_coef(AXIS, k));
        logic signed [GRAD_W-1:0] pix_ext;
        assign pix_ext   = signed'({{(GRAD_W-PIX_W){1'b0}}, win[k*PIX_W +: PIX_W]});
        assign prod_d[k] = pix_ext * COEF;
    end

    // Stage 1: hold the weighted taps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_TAPS; k++) prod_q[k] <= '0;
        end else begin
            for (int k = 0; k < N_TAPS; k++) prod_q[k] <= prod_d[k];
        end
    end

    // Adder tree input: sum of the held taps.
    always_comb begin
        sum_d = '0;
        for (int k = 0; k < N_TAPS; k++) sum_d = sum_d + prod_q[k];
    end

    // Stage 2: hold the gradient.
    always_ff @(posedge clk) begin
        if (!rst_n) grad_q <= '0;
        else        grad_q <= sum_d;
    end

    assign grad = grad_q;

endmodule

// File: rtl/sobel_mag_thresh.sv
// Module: squares both signed gradients, adds the squares and compares the
// sum with THRESH, then registers the binary edge pixel. Assumes the
// gradients fit GRAD_W bits. The output is forced to zero when the stage is
// not carrying valid data.
module sobel_mag_thresh #(
    parameter int PIX_W  = sobel_edge_pkg::PIX_W,
    parameter int GRAD_W = PIX_W + 3,
    parameter int THRESH = sobel_edge_pkg::EDGE_THRESH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stage_valid,
    input  logic signed [GRAD_W-1:0] gx,
    input  logic signed [GRAD_W-1:0] gy,
    output logic [PIX_W-1:0]         edge_pix
);

    localparam int SQ_W = 2 * GRAD_W;

    logic signed [SQ_W-1:0] gx_w;
    logic signed [SQ_W-1:0] gy_w;
    logic signed [SQ_W-1:0] sq_x;
    logic signed [SQ_W-1:0] sq_y;
    logic        [SQ_W-1:0] mag_sq;
    logic                   over;
    logic [PIX_W-1:0]       pix_q;

    // Sign-extend, square, add and compare (strictly greater).
    always_comb begin
        gx_w   = SQ_W'(gx);
        gy_w   = SQ_W'(gy);
        sq_x   = gx_w * gx_w;
        sq_y   = gy_w * gy_w;
        mag_sq = $unsigned(sq_x) + $unsigned(sq_y);
        over   = mag_sq > SQ_W'(THRESH);
    end

    // Stage 3: register white/black, black for empty slots.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pix_q <= '0;
        else if (stage_valid && over) pix_q <= {PIX_W{1'b1}};
        else                          pix_q <= '0;
    end

    assign edge_pix = pix_q;

endmodule

// File: rtl/sobel_valid_delay.sv
// Module: shift register that carries the valid strobe beside the data
// pipeline and exposes every tap. Assumes DEPTH >= 2.
module sobel_valid_delay #(
    parameter int DEPTH = sobel_edge_pkg::PIPE_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vin,
    output logic [DEPTH-1:0] taps
);

    logic [DEPTH-1:0] sr_q;

    // Shift the strobe one stage per cycle, clearing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[DEPTH-2:0], vin};
    end

    assign taps = sr_q;

endmodule

// File: rtl/sobel_edge_thresh.sv
// Module: top of the Sobel gradient threshold unit. Runs two gradient lanes
// in parallel on the same window, feeds both into the squared-magnitude
// comparator, and aligns the valid strobe with a matching delay line.
// Latency is three cycles. Assumes a single clock and a synchronous
// active-low reset.
module sobel_edge_thresh #(
    parameter int PIX_W  = sobel_edge_pkg::PIX_W,
    parameter int THRESH = sobel_edge_pkg::EDGE_THRESH
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [sobel_edge_pkg::N_TAPS*PIX_W-1:0] in_win,
    output logic                                   out_valid,
    output logic [PIX_W-1:0]                       out_pix
);

    localparam int GRAD_W = PIX_W + 3;
    localparam int DEPTH  = sobel_edge_pkg::PIPE_DEPTH;
    localparam int N_AXES = 2;

    logic [N_AXES-1:0][GRAD_W-1:0] grad_pk;
    logic signed [GRAD_W-1:0]      gx_s;
    logic signed [GRAD_W-1:0]      gy_s;
    logic [DEPTH-1:0]              vld_taps;

    // One lane per axis; the lane index selects the kernel.
    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        logic signed [GRAD_W-1:0] lane_grad;
        sobel_axis_lane #(
            .PIX_W (PIX_W),
            .AXIS  (sobel_edge_pkg::axis_e'(a))
        ) lane_i (
            .clk   (clk),
            .rst_n (rst_n),
            .win   (in_win),
            .grad  (lane_grad)
        );
        assign grad_pk[a] = lane_grad;
    end

    assign gx_s = signed'(grad_pk[0]);
    assign gy_s = signed'(grad_pk[1]);

    // Valid delay line matching the three data stages.
    sobel_valid_delay #(
        .DEPTH (DEPTH)
    ) vld_i (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (in_valid),
        .taps  (vld_taps)
    );

    // Squared magnitude and threshold; uses the stage-2 strobe.
    sobel_mag_thresh #(
        .PIX_W  (PIX_W),
        .GRAD_W (GRAD_W),
        .THRESH (THRESH)
    ) mag_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .stage_valid (vld_taps[DEPTH-2]),
        .gx          (gx_s),
        .gy          (gy_s),
        .edge_pix    (out_pix)
    );

    assign out_valid = vld_taps[DEPTH-1];

endmodule

// File: rtl/sobel_edge_thresh_chk.sv
// Module: assertion checker for sobel_edge_thresh, attached by bind. It
// watches the ports and the two gradients passed between the lanes and the
// comparator.
module sobel_edge_thresh_chk #(
    parameter int PIX_W  = 8,
    parameter int GRAD_W = PIX_W + 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic [PIX_W-1:0]         out_pix,
    input logic signed [GRAD_W-1:0] gx,
    input logic signed [GRAD_W-1:0] gy
);

    localparam int GRAD_LIM = 4 * ((1 << PIX_W) - 1);

    logic [1:0] age_q;

    // Count edges since reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R7: reset empties the outputs by the next edge
    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_pix == '0));

    // R5: out_valid is in_valid three cycles earlier
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R6: idle slots are black
    assert_idle_black_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_pix == '0));

    // R9: only black or white is ever emitted
    assert_binary_pix_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pix == '0) || (out_pix == {PIX_W{1'b1}}));

    // R3: lane results stay inside the reachable signed range
    assert_grad_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(gx) <= GRAD_LIM) && (int'(gx) >= -GRAD_LIM) &&
        (int'(gy) <= GRAD_LIM) && (int'(gy) >= -GRAD_LIM));

endmodule

bind sobel_edge_thresh sobel_edge_thresh_chk #(
    .PIX_W  (PIX_W),
    .GRAD_W (GRAD_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_pix   (out_pix),
    .gx        (gx_s),
    .gy        (gy_s)
);

// File: tb/sobel_edge_thresh_tb_top.sv
`timescale 1ns/1ps
// Bench: directed threshold and kernel corners plus seeded random windows,
// checked against a model built from the requirement formulas.
module sobel_edge_thresh_tb_top;

    localparam int PIX_W = 8;
    localparam int WIN_W = 9 * PIX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [WIN_W-1:0] in_win = '0;
    logic             out_valid;
    logic [PIX_W-1:0] out_pix;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    hv [3];
    bit    he [3];
    string ht [3];

    always #4 clk = ~clk;   // 125 MHz

    sobel_edge_thresh dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_win    (in_win),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    // Model of R1, R2 and R4: the formulas written out directly.
    function automatic bit ref_edge(input logic [WIN_W-1:0] w);
        int p [9];
        int gx;
        int gy;
        for (int k = 0; k < 9; k++) p[k] = {24'd0, w[k*8 +: 8]};
        gx = p[2] + 2*p[5] + p[8] - p[0] - 2*p[3] - p[6];
        gy = p[6] + 2*p[7] + p[8] - p[0] - 2*p[1] - p[2];
        return (gx*gx + gy*gy) > 4000;
    endfunction

    function automatic logic [WIN_W-1:0] px(input int idx, input int val);
        logic [WIN_W-1:0] r;
        r = '0;
        r[idx*8 +: 8] = 8'(val);
        return r;
    endfunction

    function automatic logic [WIN_W-1:0] rnd_win(input bit low);
        logic [WIN_W-1:0] r;
        int base;
        base = int'($urandom % 240);
        for (int k = 0; k < 9; k++)
            r[k*8 +: 8] = low ? 8'(base + int'($urandom % 16)) : 8'($urandom % 256);
        return r;
    endfunction

    task automatic fail(input string req, input int act, input int exp);
        errors++;
        $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    endtask

    // Compare outputs against the entry pushed three steps earlier (R5, R6, R9).
    task automatic check_out();
        logic [7:0] exp_pix;
        string      tag;
        checks++;
        if (out_valid !== hv[2]) fail("R5", int'(out_valid), int'(hv[2]));
        exp_pix = (hv[2] && he[2]) ? 8'hFF : 8'h00;
        tag     = hv[2] ? ht[2] : "R6";
        checks++;
        if (out_pix !== exp_pix) fail(tag, int'(out_pix), int'(exp_pix));
    endtask

    task automatic step(input bit v, input logic [WIN_W-1:0] w, input string tag);
        @(negedge clk);
        check_out();
        hv[2] = hv[1]; he[2] = he[1]; ht[2] = ht[1];
        hv[1] = hv[0]; he[1] = he[0]; ht[1] = ht[0];
        hv[0] = v; he[0] = ref_edge(w); ht[0] = tag;
        in_valid = v;
        in_win   = w;
    endtask

    // R7: hold reset with valid traffic on the input; outputs must read zero.
    task automatic reset_phase(input int n);
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_win   = rnd_win(1'b0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || out_pix !== 8'h00)
                fail("R7", int'({out_valid, out_pix}), 0);
        end
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; he[i] = 1'b0; ht[i] = "R7";
        end
        rst_n    = 1'b1;
        in_valid = 1'b0;
        in_win   = '0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; he[i] = 1'b0; ht[i] = "R7"; end
        reset_phase(4);

        // R1: horizontal weights and signs
        step(1'b1, px(5, 40), "R1");              // gx=80  -> white
        step(1'b1, px(3, 40), "R1");              // gx=-80 -> white
        step(1'b1, px(5, 31), "R1");              // 3844   -> black
        step(1'b1, px(0, 45), "R1");              // 4050   -> white
        step(1'b1, px(0, 44), "R1");              // 3872   -> black
        // R2: vertical weights, centre ignored
        step(1'b1, px(1, 32), "R2");              // gy=-64 -> white
        step(1'b1, px(7, 31), "R2");              // 3844   -> black
        step(1'b1, px(4, 255), "R2");             // centre only -> black
        // R4: exact threshold and just above
        step(1'b1, px(5, 30) | px(7, 10), "R4");  // exactly 4000 -> black
        step(1'b1, px(5, 32), "R4");              // 4096 -> white
        // R3: extreme and negative gradients
        step(1'b1, px(2,255)|px(5,255)|px(8,255), "R3");
        step(1'b1, px(0,255)|px(3,255)|px(6,255), "R3");
        step(1'b1, px(0,255)|px(1,255)|px(2,255)|px(3,255), "R3");
        step(1'b1, px(2,255)|px(5,255)|px(8,255)|px(6,255)|px(7,255), "R3");
        // R6: bubbles carrying windows that would be edges
        step(1'b0, px(5, 200), "R6");
        step(1'b1, px(5, 31), "R1");
        step(1'b0, px(3, 200), "R6");

        // Random mix, valid about 75 percent of the time
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) != 0, rnd_win(($urandom % 2) == 0), "R4");

        // R8: back-to-back stream
        for (int i = 0; i < 60; i++)
            step(1'b1, rnd_win(($urandom % 2) == 0), "R8");

        // R7: reset with the pipeline full, then resume
        reset_phase(2);
        for (int i = 0; i < 20; i++)
            step(1'b1, rnd_win(1'b1), "R8");
        for (int i = 0; i < 4; i++)
            step(1'b0, '0, "R6");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(64'd8 * 64'd200000);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule